// File: doc/BRIEF.md
# Multi-function 32-bit integer ALU

This block is the arithmetic core of a small execute stage. It takes two 32-bit operands and a 4-bit function code, and it returns one 32-bit result in the same cycle. It has no clock, no reset and no state. The caller registers the result where the pipeline needs it.

The function set covers four groups of operations. The first is wrap-around addition and subtraction. The second is the three bitwise logic operations. The third is the three shift flavours. The rest are a signed less-than test, unsigned quotient and remainder, the low product word, the high product word in signed and unsigned forms, and a pass-through of the second operand. Overflow is never reported, and no flags come out of the block.

Top module: `int_alu`

## Requirements
- R1: Code 0 gives opa + opb and code 12 gives opa - opb, both taken modulo 2^32 with any carry or borrow dropped.
- R2: Code 1 gives the bitwise AND of the operands, code 2 the bitwise OR and code 3 the bitwise XOR.
- R3: Shifts use only opb[4:0] as the distance. Code 4 shifts opa right and fills with zeros. Code 5 shifts opa right and fills with copies of opa[31]. Code 6 shifts opa left and fills with zeros.
- R4: Code 7 gives 32'd1 when opa is less than opb as two's-complement numbers, and 32'd0 otherwise.
- R5: Code 8 gives the unsigned quotient opa / opb rounded toward zero. When opb is zero it gives 0xFFFFFFFF.
- R6: Code 9 gives the unsigned remainder opa % opb. When opb is zero it gives opa unchanged.
- R7: Code 10 gives bits [31:0] of the product opa * opb.
- R8: Code 11 gives bits [63:32] of the product with both operands read as unsigned.
- R9: Code 14 gives bits [63:32] of the product with both operands read as signed two's-complement.
- R10: Code 13 gives opb unchanged, and opa has no effect on the result.
- R11: Code 15 is unused and gives 32'd0 whatever the operands are.
- R12: The result depends only on the present inputs. It settles within the same cycle in which the inputs change, with no latency and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand; its low 5 bits are the shift distance |
| fsel | input | 4 | Function code, encoded as listed in the requirements |
| result | output | 32 | Outcome of the selected function |

## Verification
The hardest cases to reach are at the edges of the divider and the signed high product. These are a zero divisor, a dividend below the divisor, and operands at 0x80000000 or all ones, where the signed and unsigned high words differ. Random operands almost never produce them. The stimulus therefore starts with a directed corner list that names each of these values. A random sweep over every function code follows. In that sweep, one vector in four has its divisor forced to zero or to a small value, and its operands biased toward the sign-boundary values.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W    = 32,
  parameter int SELW = 4
) (
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [SELW-1:0] fsel,
  output logic [W-1:0]    result
);
  localparam int SHW = $clog2(W);

  localparam logic [SELW-1:0] F_ADD   = SELW'(0);
  localparam logic [SELW-1:0] F_AND   = SELW'(1);
  localparam logic [SELW-1:0] F_OR    = SELW'(2);
  localparam logic [SELW-1:0] F_XOR   = SELW'(3);
  localparam logic [SELW-1:0] F_SHRL  = SELW'(4);
  localparam logic [SELW-1:0] F_SHRA  = SELW'(5);
  localparam logic [SELW-1:0] F_SHL   = SELW'(6);
  localparam logic [SELW-1:0] F_LTS   = SELW'(7);
  localparam logic [SELW-1:0] F_QUO   = SELW'(8);
  localparam logic [SELW-1:0] F_REM   = SELW'(9);
  localparam logic [SELW-1:0] F_MULLO = SELW'(10);
  localparam logic [SELW-1:0] F_MULHU = SELW'(11);
  localparam logic [SELW-1:0] F_SUB   = SELW'(12);
  localparam logic [SELW-1:0] F_PASSB = SELW'(13);
  localparam logic [SELW-1:0] F_MULHS = SELW'(14);

  logic [SHW-1:0] shamt;
  assign shamt = opb[SHW-1:0];

  // shared adder: subtract and signed compare both use the inverted operand
  logic           negate;
  logic [W-1:0]   sum;
  logic           lt_s;
  assign negate = (fsel == F_SUB) || (fsel == F_LTS);
  assign sum    = opa + (opb ^ {W{negate}}) + {{(W-1){1'b0}}, negate};
  assign lt_s   = (opa[W-1] != opb[W-1]) ? opa[W-1] : sum[W-1];

  // one multiplier: operands widened by one bit, sign bit only for the signed high word
  logic               sgn_mul;
  logic signed [W:0]  ma, mb;
  logic signed [2*W-1:0] prod;
  assign sgn_mul = (fsel == F_MULHS);
  assign ma      = {sgn_mul & opa[W-1], opa};
  assign mb      = {sgn_mul & opb[W-1], opb};
  assign prod    = ma * mb;

  // restoring divider, unrolled; a zero divisor naturally yields all-ones and opa
  logic [W-1:0] quo, rmd;
  logic [W:0]   part;
  always_comb begin
    part = '0;
    quo  = '0;
    for (int i = W - 1; i >= 0; i--) begin
      part = {part[W-1:0], opa[i]};
      if (part >= {1'b0, opb}) begin
        part   = part - {1'b0, opb};
        quo[i] = 1'b1;
      end
    end
    rmd = part[W-1:0];
  end

  always_comb begin
    unique case (fsel)
      F_ADD, F_SUB: result = sum;
      F_AND:        result = opa & opb;
      F_OR:         result = opa | opb;
      F_XOR:        result = opa ^ opb;
      F_SHRL:       result = opa >> shamt;
      F_SHRA:       result = $signed(opa) >>> shamt;
      F_SHL:        result = opa << shamt;
      F_LTS:        result = {{(W-1){1'b0}}, lt_s};
      F_QUO:        result = quo;
      F_REM:        result = rmd;
      F_MULLO:      result = prod[W-1:0];
      F_MULHU,
      F_MULHS:      result = prod[2*W-1:W];
      F_PASSB:      result = opb;
      default:      result = '0;
    endcase

    if (fsel == F_LTS)
      AST_LTS_BOOLEAN: assert (result[W-1:1] == '0);                             // R4
    if (fsel == F_SHRL && shamt != '0)
      AST_SHRL_ZERO_FILL: assert (result[W-1] == 1'b0);                         // R3
    if (fsel == F_SHRA)
      AST_SHRA_SIGN_KEPT: assert (result[W-1] == opa[W-1]);                     // R3
    if (fsel == F_QUO && opb == '0)
      AST_QUO_BY_ZERO: assert (result == '1);                                   // R5
    if (fsel == F_QUO && opb != '0)
      AST_QUO_BOUND: assert (result <= opa);                                    // R5
    if (fsel == F_REM && opb == '0)
      AST_REM_BY_ZERO: assert (result == opa);                                  // R6
    if (fsel == F_REM && opb != '0)
      AST_REM_BOUND: assert (result < opb);                                     // R6
    if (fsel == F_MULHS && opa != '0 && opb != '0)
      AST_MULHS_SIGN: assert (result[W-1] == (opa[W-1] ^ opb[W-1]));            // R9
  end
endmodule

// File: tb/int_alu_test.sv
module int_alu_test;
  logic        clk = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [3:0]  fsel = '0;
  logic [31:0] result;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  op;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t sb[$];

  always #4 clk = ~clk;

  int_alu uut (.opa(opa), .opb(opb), .fsel(fsel), .result(result));

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] op);
    logic signed [63:0] ps;
    logic [63:0]        pu;
    ps = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    pu = {32'b0, a} * {32'b0, b};
    case (op)
      4'd0:  return a + b;
      4'd1:  return a & b;
      4'd2:  return a | b;
      4'd3:  return a ^ b;
      4'd4:  return a >> b[4:0];
      4'd5:  return 32'($signed(a) >>> b[4:0]);
      4'd6:  return a << b[4:0];
      4'd7:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd8:  return (b == 0) ? 32'hFFFF_FFFF : a / b;
      4'd9:  return (b == 0) ? a : a % b;
      4'd10: return pu[31:0];
      4'd11: return pu[63:32];
      4'd12: return a - b;
      4'd13: return b;
      4'd14: return ps[63:32];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd12:       return "R1";
      4'd1, 4'd2, 4'd3:  return "R2";
      4'd4, 4'd5, 4'd6:  return "R3";
      4'd7:              return "R4";
      4'd8:              return "R5";
      4'd9:              return "R6";
      4'd10:             return "R7";
      4'd11:             return "R8";
      4'd13:             return "R10";
      4'd14:             return "R9";
      default:           return "R11";
    endcase
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
    item_t it;
    @(posedge clk);
    #1;
    opa = a; opb = b; fsel = op;
    it.a = a; it.b = b; it.op = op; it.exp = model(a, b, op); it.req = req_of(op);
    sb.push_back(it);
  endtask

  // monitor: result must be valid in the same cycle as its inputs (R12)
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_vec++;
      if (result !== it.exp) begin
        n_bad++;
        $display("FAIL %s (R12 same-cycle) op=%0d a=%h b=%h actual=%h expected=%h",
                 it.req, it.op, it.a, it.b, result, it.exp);
      end
    end
  end

  function automatic logic [31:0] edge_val(input int unsigned r);
    case (r % 6)
      0: return 32'h8000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h7FFF_FFFF;
      3: return 32'd1;
      4: return 32'd0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    drive(32'h0, 32'h0, 4'd0);                       // R1 idle inputs give zero
    drive(32'hFFFF_FFFF, 32'h1, 4'd0);               // R1 wrap
    drive(32'h0, 32'h1, 4'd12);                      // R1 borrow wrap
    drive(32'h8000_0000, 32'h1, 4'd12);              // R1
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'd1);       // R2
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'd2);       // R2
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'd3);       // R2
    drive(32'h8000_0001, 32'h0000_0023, 4'd4);       // R3 distance from low bits only
    drive(32'h8000_0001, 32'h0000_001F, 4'd5);       // R3 sign fill
    drive(32'h8000_0001, 32'h0000_0000, 4'd5);       // R3 zero distance
    drive(32'h8000_0001, 32'hFFFF_FFE1, 4'd6);       // R3
    drive(32'hFFFF_FFFF, 32'h1, 4'd7);               // R4 -1 < 1
    drive(32'h1, 32'hFFFF_FFFF, 4'd7);               // R4
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'd7);       // R4 extremes
    drive(32'h5, 32'h5, 4'd7);                       // R4 equal
    drive(32'h1234_5678, 32'h0, 4'd8);               // R5 zero divisor
    drive(32'h8000_0000, 32'h3, 4'd8);               // R5
    drive(32'h3, 32'h8000_0000, 4'd8);               // R5 small dividend
    drive(32'h1234_5678, 32'h0, 4'd9);               // R6 zero divisor
    drive(32'hFFFF_FFFF, 32'h10, 4'd9);              // R6
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd10);      // R7
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd11);      // R8
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd14);      // R9 -1 * -1
    drive(32'h8000_0000, 32'h8000_0000, 4'd14);      // R9
    drive(32'hFFFF_FFFF, 32'h1, 4'd14);              // R9
    drive(32'hDEAD_BEEF, 32'h0BAD_F00D, 4'd13);      // R10
    drive(32'h0, 32'h0BAD_F00D, 4'd13);              // R10 opa has no effect
    drive(32'hDEAD_BEEF, 32'h0BAD_F00D, 4'd15);      // R11
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd15);      // R11
    for (int k = 0; k < 3200; k++) begin
      logic [31:0] a, b;
      int unsigned r;
      r = $urandom;
      a = $urandom;
      b = $urandom;
      if (r % 4 == 0) begin
        a = edge_val(r >> 3);
        b = edge_val(r >> 7);
        if (r[12]) b = 32'(r[15:13]);
      end
      drive(a, b, 4'(k % 16));
    end
    @(posedge clk);
    wait (sb.size() == 0);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL R12 watchdog expired actual=hung expected=complete");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule